// File: doc/BRIEF.md
# SDRAM Initialization and Refresh Sequencer

This block drives the command pins of a registered SDRAM module from the moment reset is released. It first waits out the power-up hold-off and the clock-PLL settling interval. It then runs the fixed bring-up sequence: one precharge of all banks, eight auto refreshes, and a mode register load. After that it raises `ready_o` and keeps the memory refreshed. Read, write and row traffic belong to a neighbouring controller. That controller watches `ready_o`, grants refresh slots through a request/acknowledge pair, and asks for self refresh when the system goes quiet.

All timing is given in clock cycles through parameters. The power-up pause is derived from a clock frequency in MHz and a pause length in microseconds. The module's input register delays every command by `REG_LAT` cycles. The sequencer adds that latency to each interval that ends in handing the interface back to the user. If a refresh request goes unanswered for a whole further interval, the sequencer takes the slot by itself and issues two refreshes back to back. Self-refresh exit is timed from the second rising edge after CKE returns high.

Top module: `sdram_seq`

## Requirements
- R1: While `rst_ni` is low, `cs_n_o`=1, RAS#/CAS#/WE#=1/1/1, `cke_o`=1, `addr_o`=0, `ready_o`=0 and `ref_req_o`=0. After the first clock edge that follows reset release, `cs_n_o` is 0.
- R2: From reset release, only NOP is driven for W clock edges, where W = max(CLK_MHZ*PAUSE_US, TSTAB_CYC). The first command appears on pins after edge W and is Precharge All.
- R3: Precharge All is followed after TRP_CYC cycles by exactly INIT_AREF auto refreshes, which are TRC_CYC cycles apart. The mode register load follows TRC_CYC cycles after the last of them and carries `mode_i` on `addr_o`. Every cycle between these commands is NOP.
- R4: `ready_o` first rises TMRD_CYC+REG_LAT cycles after the mode register load appears on pins.
- R5: The command encodings on RAS#,CAS#,WE# are: NOP=1,1,1; Precharge All=0,1,0 with `addr_o[10]`=1; Auto Refresh=0,0,1; Mode Register Set=0,0,0. Only the mode register load drives a nonzero address apart from bit 10 of Precharge All.
- R6: `ref_req_o` goes high once REFI_CYC cycles have passed since the last auto refresh after initialization. When `ready_o`, `ref_req_o` and `ref_ack_i` are all high at an edge, one auto refresh is issued on that edge and `ref_req_o` falls.
- R7: When the interval count reaches 2*REFI_CYC while the block is idle, the block issues two auto refreshes TRC_CYC apart without any acknowledge.
- R8: When `sref_req_i` is high at an edge while idle, an auto refresh with `cke_o`=0 is issued. `cke_o` then stays low, with NOP on the command pins, for as long as `sref_req_i` stays high.
- R9: When `sref_req_i` is low at an edge during self refresh, `cke_o` rises. Only NOP follows, and `ready_o` returns 2+TRC_CYC+REG_LAT cycles after `cke_o` rises.
- R10: `ready_o` falls on the edge that issues any refresh. It returns TRC_CYC+REG_LAT cycles after the last refresh of a normal or forced refresh.
- R11: `ref_ack_i` has no effect while `ref_req_o` is low, and `sref_req_i` has no effect while `ready_o` is low. In both cases only NOP appears on the pins.
- R12: The idle priority is forced refresh first, then self refresh, then acknowledged refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | ADDR_W | Value placed on the address pins during the mode register load |
| ref_ack_i | input | 1 | User grants the pending refresh slot |
| sref_req_i | input | 1 | Level request to enter and stay in self refresh |
| ready_o | output | 1 | Interface free for user commands |
| ref_req_o | output | 1 | Refresh due |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| addr_o | output | ADDR_W | Address pins |

## Verification
The bench builds the block with a 1 MHz clock parameter, a 100 µs pause and TSTAB_CYC=120. The settling interval therefore dominates the hold-off, and bring-up ends after 174 edges. With TRP_CYC=3, TRC_CYC=6, TMRD_CYC=2 and REFI_CYC=40, one run covers several acknowledged refreshes and a forced double refresh at count 80. It also covers a self-refresh request that collides with a pending acknowledge, and a self-refresh request held off by a refresh in progress.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PREA,
    CMD_AREF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_INIT_AR,
    ST_MRS,
    ST_WAIT,
    ST_IDLE,
    ST_MISS,
    ST_SREF
  } state_e;

  // {ras_n, cas_n, we_n}
  function automatic logic [2:0] cmd_bits(cmd_e c);
    case (c)
      CMD_PREA: return 3'b010;
      CMD_AREF: return 3'b001;
      CMD_MRS:  return 3'b000;
      default:  return 3'b111;
    endcase
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_seq_tmr.sv
module sdram_seq_tmr #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= W'(RST_VAL);
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // spacing rules: a new interval only starts once the previous one is over
  assert_load_at_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> zero_o);

endmodule

// File: rtl/sdram_seq_refi.sv
module sdram_seq_refi #(
  parameter int REFI = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hold_i,
  output logic req_o,
  output logic miss_o
);

  localparam int LIM = 2 * REFI;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i || hold_i)     cnt_q <= '0;
    else if (cnt_q < CW'(LIM))    cnt_q <= cnt_q + 1'b1;
  end

  assign req_o  = (cnt_q >= CW'(REFI));
  assign miss_o = (cnt_q >= CW'(LIM));

  assert_req_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !req_o);

  assert_miss_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_o && !clr_i && !hold_i) |=> miss_o);

endmodule

// File: rtl/sdram_seq_pins.sv
module sdram_seq_pins
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic              cke_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic [ADDR_W-1:0] addr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_o                      <= 1'b1;
      {ras_n_o, cas_n_o, we_n_o}  <= 3'b111;
      cke_o                       <= 1'b1;
      addr_o                      <= '0;
    end else begin
      cs_n_o                      <= 1'b0;
      {ras_n_o, cas_n_o, we_n_o}  <= cmd_bits(cmd_i);
      cke_o                       <= cke_i;
      addr_o                      <= addr_i;
    end
  end

  // entering self refresh: CKE falls together with an auto refresh
  assert_sre_enc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && $past(cke_o)) |-> (!ras_n_o && !cas_n_o && we_n_o));

  assert_cke_low_nop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && !$past(cke_o)) |-> (ras_n_o && cas_n_o && we_n_o));

  assert_prea_a10_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && cas_n_o && !we_n_o) |-> addr_o[10]);

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int PAUSE_US  = 100,
  parameter int TSTAB_CYC = 1000,
  parameter int TRP_CYC   = 3,
  parameter int TRC_CYC   = 7,
  parameter int TMRD_CYC  = 2,
  parameter int REFI_CYC  = 1560,
  parameter int INIT_AREF = 8,
  parameter int REG_LAT   = 1,
  parameter int ADDR_W    = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mode_i,
  input  logic              ref_ack_i,
  input  logic              sref_req_i,
  output logic              ready_o,
  output logic              ref_req_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int WAIT_INIT = imax(CLK_MHZ * PAUSE_US, TSTAB_CYC);
  localparam int SRX_CYC   = 2 + TRC_CYC + REG_LAT;
  localparam int MAXT      = imax(imax(WAIT_INIT, SRX_CYC),
                                  imax(TMRD_CYC + REG_LAT, TRP_CYC));
  localparam int TW        = $clog2(MAXT + 1);
  localparam int ARC_W     = $clog2(INIT_AREF + 1);

  state_e            st_q, st_d;
  cmd_e              cmd_d;
  logic              cke_d;
  logic [ADDR_W-1:0] addr_d;
  logic              rdy_q, rdy_d;
  logic              idone_q, idone_d;
  logic [ARC_W-1:0]  arc_q, arc_d;
  logic              t_load, t_zero;
  logic [TW-1:0]     t_val;
  logic              rf_clr, rf_hold, rf_req, rf_miss;

  sdram_seq_tmr #(.W(TW), .RST_VAL(WAIT_INIT - 1)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (t_val),
    .zero_o (t_zero)
  );

  assign rf_clr  = (cmd_d == CMD_AREF);
  assign rf_hold = !idone_q || !cke_o;

  sdram_seq_refi #(.REFI(REFI_CYC)) u_refi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rf_clr),
    .hold_i (rf_hold),
    .req_o  (rf_req),
    .miss_o (rf_miss)
  );

  always_comb begin
    st_d    = st_q;
    cmd_d   = CMD_NOP;
    cke_d   = cke_o;
    addr_d  = '0;
    rdy_d   = rdy_q;
    idone_d = idone_q;
    arc_d   = arc_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (st_q)
      ST_PAUSE: if (t_zero) begin
        cmd_d      = CMD_PREA;
        addr_d[10] = 1'b1;
        t_load     = 1'b1;
        t_val      = TW'(TRP_CYC - 1);
        arc_d      = '0;
        st_d       = ST_INIT_AR;
      end
      ST_INIT_AR: if (t_zero) begin
        cmd_d  = CMD_AREF;
        t_load = 1'b1;
        t_val  = TW'(TRC_CYC - 1);
        arc_d  = arc_q + 1'b1;
        if (arc_q == ARC_W'(INIT_AREF - 1)) st_d = ST_MRS;
      end
      ST_MRS: if (t_zero) begin
        cmd_d   = CMD_MRS;
        addr_d  = mode_i;
        t_load  = 1'b1;
        t_val   = TW'(TMRD_CYC + REG_LAT - 1);
        idone_d = 1'b1;
        st_d    = ST_WAIT;
      end
      ST_WAIT: if (t_zero) begin
        rdy_d = 1'b1;
        st_d  = ST_IDLE;
      end
      ST_IDLE: begin
        if (rf_miss) begin
          cmd_d  = CMD_AREF;
          t_load = 1'b1;
          t_val  = TW'(TRC_CYC - 1);
          rdy_d  = 1'b0;
          st_d   = ST_MISS;
        end else if (sref_req_i) begin
          cmd_d  = CMD_AREF;
          cke_d  = 1'b0;
          rdy_d  = 1'b0;
          st_d   = ST_SREF;
        end else if (rf_req && ref_ack_i) begin
          cmd_d  = CMD_AREF;
          t_load = 1'b1;
          t_val  = TW'(TRC_CYC + REG_LAT - 1);
          rdy_d  = 1'b0;
          st_d   = ST_WAIT;
        end
      end
      ST_MISS: if (t_zero) begin
        cmd_d  = CMD_AREF;
        t_load = 1'b1;
        t_val  = TW'(TRC_CYC + REG_LAT - 1);
        st_d   = ST_WAIT;
      end
      ST_SREF: if (!sref_req_i) begin
        cke_d  = 1'b1;
        t_load = 1'b1;
        t_val  = TW'(SRX_CYC - 1);
        st_d   = ST_WAIT;
      end
      default: st_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PAUSE;
      rdy_q   <= 1'b0;
      idone_q <= 1'b0;
      arc_q   <= '0;
    end else begin
      st_q    <= st_d;
      rdy_q   <= rdy_d;
      idone_q <= idone_d;
      arc_q   <= arc_d;
    end
  end

  sdram_seq_pins #(.ADDR_W(ADDR_W)) u_pins (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd_d),
    .cke_i   (cke_d),
    .addr_i  (addr_d),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .cke_o   (cke_o),
    .addr_o  (addr_o)
  );

  assign ready_o   = rdy_q;
  assign ref_req_o = rf_req;

  assert_ready_cke_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cke_o);

  assert_ready_after_nop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(ras_n_o && cas_n_o && we_n_o));

  assert_ack_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !rf_req && !sref_req_i) |=> (ras_n_o && cas_n_o && we_n_o));

  assert_no_ready_before_init_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idone_q |-> !ready_o);

endmodule

// File: tb/tb_sdram_seq.sv
module tb_sdram_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ = 1, PAUSE_US = 100, TSTAB = 120;
  localparam int TRP = 3, TRC = 6, TMRD = 2, REFI = 40, NAR = 8, LAT = 1, AW = 13;
  localparam int W = (CLK_MHZ * PAUSE_US > TSTAB) ? CLK_MHZ * PAUSE_US : TSTAB;
  localparam int MRS_AT = W + TRP + NAR * TRC;
  localparam int READY_AT = MRS_AT + TMRD + LAT;
  localparam logic [AW-1:0] MODE = 13'h0233;
  localparam int C_NOP = 0, C_PREA = 1, C_AREF = 2, C_MRS = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ack = 1'b0, sref = 1'b0;
  logic ready_o, ref_req_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, cke_o;
  logic [AW-1:0] addr_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdram_seq #(
    .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .TSTAB_CYC(TSTAB), .TRP_CYC(TRP),
    .TRC_CYC(TRC), .TMRD_CYC(TMRD), .REFI_CYC(REFI), .INIT_AREF(NAR),
    .REG_LAT(LAT), .ADDR_W(AW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(MODE), .ref_ack_i(ack), .sref_req_i(sref),
    .ready_o(ready_o), .ref_req_o(ref_req_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o), .we_n_o(we_n_o), .cke_o(cke_o), .addr_o(addr_o)
  );

  int checks = 0, fails = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, n);
    end
  endtask

  // R5 encodings as {ras_n,cas_n,we_n}
  function automatic int enc(int c);
    case (c)
      C_PREA:  return 2;
      C_AREF:  return 1;
      C_MRS:   return 0;
      default: return 7;
    endcase
  endfunction

  // behavioural reference
  int n = 0;
  int q_at[$], q_cmd[$];
  int refcnt, ready_at, rc, e_cmd;
  bit m_ready, m_cke, in_sref, idone, ck, id, rd;
  int e_addr, e_cs;
  string ctx = "R2";

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; q_at.delete(); q_cmd.delete();
      q_at.push_back(W); q_cmd.push_back(C_PREA);
      for (int i = 0; i < NAR; i++) begin
        q_at.push_back(W + TRP + i * TRC); q_cmd.push_back(C_AREF);
      end
      q_at.push_back(MRS_AT); q_cmd.push_back(C_MRS);
      ready_at = READY_AT;
      m_ready = 0; m_cke = 1; in_sref = 0; idone = 0; refcnt = 0;
      e_cmd = C_NOP; e_addr = 0; e_cs = 1; ctx = "R2";
    end else begin
      rc = refcnt; ck = m_cke; id = idone; rd = m_ready;
      n++; e_cmd = C_NOP; e_addr = 0; e_cs = 0;
      if (q_at.size() > 0 && q_at[0] == n) begin
        e_cmd = q_cmd[0]; void'(q_at.pop_front()); void'(q_cmd.pop_front());
        if (e_cmd == C_PREA) begin e_addr = 1 << 10; ctx = "R3"; end
        if (e_cmd == C_MRS) begin e_addr = int'(MODE); idone = 1; end
      end
      if (rd) begin
        if (rc >= 2 * REFI) begin
          e_cmd = C_AREF; q_at.push_back(n + TRC); q_cmd.push_back(C_AREF);
          m_ready = 0; ready_at = n + 2 * TRC + LAT; ctx = "R7";
        end else if (sref) begin
          e_cmd = C_AREF; m_cke = 0; in_sref = 1; m_ready = 0;
          ctx = (rc >= REFI && ack) ? "R12" : "R8";
        end else if (rc >= REFI && ack) begin
          e_cmd = C_AREF; m_ready = 0; ready_at = n + TRC + LAT; ctx = "R6";
        end
      end else if (in_sref && !sref) begin
        m_cke = 1; in_sref = 0; ready_at = n + 2 + TRC + LAT; ctx = "R9";
      end
      if (ready_at == n) begin m_ready = 1; ctx = "R11"; end
      if (e_cmd == C_AREF) refcnt = 0;
      else if (!id || !ck) refcnt = 0;
      else if (rc < 2 * REFI) refcnt = rc + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && n > 0) begin
      chk({ctx, "/R5 cmd"}, int'({ras_n_o, cas_n_o, we_n_o}), enc(e_cmd));
      chk({ctx, "/R5 addr"}, int'(addr_o), e_addr);
      chk("R1 cs_n", int'(cs_n_o), e_cs);
      chk({ctx, "/R8 cke"}, int'(cke_o), int'(m_cke));
      chk({ctx, "/R10 ready"}, int'(ready_o), int'(m_ready));
      chk("R6 ref_req", int'(ref_req_o), int'(refcnt >= REFI));
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R4 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", int'(cs_n_o), 1);
    chk("R1 cmd", int'({ras_n_o, cas_n_o, we_n_o}), 7);
    chk("R1 cke", int'(cke_o), 1);
    chk("R1 ready", int'(ready_o), 0);
    chk("R1 ref_req", int'(ref_req_o), 0);
    chk("R1 addr", int'(addr_o), 0);
    rst_n = 1'b1;
    while (!ready_o) @(negedge clk);
    chk("R4 ready edge", n, READY_AT);
    // R11: ack while no request pending
    ack = 1'b1; repeat (10) @(negedge clk); ack = 1'b0;
    // R6: acknowledged refresh
    while (!ref_req_o) @(negedge clk);
    repeat (3) @(negedge clk);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R6 req dropped", int'(ref_req_o), 0);
    // R7: leave request unanswered until forced
    while (ready_o) @(negedge clk);
    repeat (2) @(negedge clk);
    while (!ready_o) @(negedge clk);
    while (!ref_req_o) @(negedge clk);
    while (ready_o) @(negedge clk);
    while (!ready_o) @(negedge clk);
    // R12: self refresh beats a pending acknowledge
    while (!ref_req_o) @(negedge clk);
    sref = 1'b1; ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R12 cke low", int'(cke_o), 0);
    repeat (15) @(negedge clk);
    sref = 1'b0;
    while (!ready_o) @(negedge clk);
    // R11: self refresh request held off while a refresh runs
    while (!ref_req_o) @(negedge clk);
    ack = 1'b1; @(negedge clk); ack = 1'b0; sref = 1'b1;
    chk("R11 cke high while busy", int'(cke_o), 1);
    while (cke_o) @(negedge clk);
    repeat (5) @(negedge clk);
    sref = 1'b0;
    while (!ready_o) @(negedge clk);
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule